// File: doc/BRIEF.md
# Fault-Injectable Two-Level AND-OR Logic Array

This block models a programmable two-level logic array in synthesizable logic. A product-term plane holds one three-valued coordinate per input for each term. A connection plane selects which terms feed each output's OR gate. A per-output polarity vector can complement any output. All three stores are loaded through a single register write port. An applied input vector is evaluated combinationally, and the outputs are captured when a valid strobe is presented.

A fault port can alter exactly one programming point, either a product-term coordinate or a connection bit, to emulate one of four connection faults:

- **Growth:** a literal is dropped from its term.
- **Shrinkage:** an absent input is wrongly attached to a term.
- **Disappearance:** a term is cut from an output.
- **Appearance:** a term is wrongly tied to an output.

The fault is an overlay on the stored arrays. Arming a new fault replaces the old one. Clearing it restores fault-free behaviour without any reload. The block lets a test set for an array be tried against every single-fault variant of that array.

Top module: `pla_fault_array`

## Requirements
- R1: After reset every coordinate reads as absent, every connection bit is 0 and the polarity vector is 0, so any evaluated input gives all-zero outputs; `z_o` and `out_valid_o` are 0 out of reset.
- R2: A coordinate is 2 bits, bits [2i+1:2i] of a term row for input i: 01 requires the input to be 1, 10 requires it to be 0, 11 ignores it, and 00 forces the whole term to 0.
- R3: Output o is the OR of all terms whose connection bit o is set, XORed with polarity bit o.
- R4: When `in_valid_i` is high at a clock edge, `z_o` shows the result for `in_vec_i` and `out_valid_o` is 1 after that edge; with no strobe, `out_valid_o` is 0 and `z_o` holds.
- R5: The write target is selected by `wr_sel_i`: 00 writes term row `wr_row_i`, 01 writes connection row `wr_row_i` (bit o for output o), and 10 writes the polarity vector. Code 11 and row indices past the last term change nothing.
- R6: Fault kind 0 (growth) turns a coordinate at (`flt_row_i`, input `flt_col_i`) that holds 01 or 10 into 11. It has no effect on a coordinate that holds 11 or 00.
- R7: Fault kind 1 (shrinkage) turns a coordinate holding 11 into 01 when `flt_val_i` is 1 and into 10 when it is 0. It has no effect on any other code.
- R8: Fault kind 2 (disappearance) forces connection bit (`flt_row_i`, output `flt_col_i`) to 0.
- R9: Fault kind 3 (appearance) forces that connection bit to 1.
- R10: At most one fault is active. `flt_set_i` replaces any armed fault, `flt_clr_i` disarms it, and clear wins when both are high.
- R11: Faults never modify the stored arrays; after a clear the outputs match the programmed function with no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target select |
| wr_row_i | input | ROW_W | Term row for plane writes |
| wr_data_i | input | WD_W | Write data |
| flt_set_i | input | 1 | Arm a fault |
| flt_clr_i | input | 1 | Disarm the fault |
| flt_type_i | input | 2 | Fault kind |
| flt_row_i | input | ROW_W | Term row of the fault |
| flt_col_i | input | COL_W | Input index (kinds 0, 1) or output index (kinds 2, 3) |
| flt_val_i | input | 1 | Forced literal for shrinkage |
| in_valid_i | input | 1 | Evaluation strobe |
| in_vec_i | input | N_IN | Input vector |
| out_valid_o | output | 1 | Result valid |
| z_o | output | N_OUT | Evaluated outputs |

## Verification
The hardest situations to reach are faults whose precondition does not hold: a growth fault aimed at an absent or illegal coordinate, or a shrinkage fault aimed at a literal. These must leave the function untouched, and they look identical to a correctly applied fault that happens to be invisible. The stimulus programs a small array with every coordinate code present, including the illegal one. It then arms every fault kind at every row and column, with both forced values. After each fault it sweeps the full input space, so every precondition case is met and every observable change is compared against an arithmetic model of the requirements.

// File: rtl/pla_fault_pkg.sv
package pla_fault_pkg;
  typedef enum logic [1:0] {
    FLT_GROW   = 2'd0,
    FLT_SHRINK = 2'd1,
    FLT_DROP   = 2'd2,
    FLT_ADD    = 2'd3
  } flt_kind_e;

  localparam logic [1:0] CODE_ONE    = 2'b01;
  localparam logic [1:0] CODE_ZERO   = 2'b10;
  localparam logic [1:0] CODE_ABSENT = 2'b11;

  localparam logic [1:0] SEL_CUBE = 2'b00;
  localparam logic [1:0] SEL_CONN = 2'b01;
  localparam logic [1:0] SEL_INV  = 2'b10;
endpackage

// File: rtl/pla_prog_store.sv
module pla_prog_store
  import pla_fault_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_TERM = 48,
  parameter int N_OUT  = 8,
  parameter int ROW_W  = 6,
  parameter int WD_W   = 32
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  wr_en_i,
  input  logic [1:0]                            wr_sel_i,
  input  logic [ROW_W-1:0]                      wr_row_i,
  input  logic [WD_W-1:0]                       wr_data_i,
  output logic [N_TERM-1:0][2*N_IN-1:0]         cube_o,
  output logic [N_TERM-1:0][N_OUT-1:0]          conn_o,
  output logic [N_OUT-1:0]                      inv_o
);
  logic [2*N_IN-1:0] cube_q [N_TERM];
  logic [N_OUT-1:0]  conn_q [N_TERM];
  logic [N_OUT-1:0]  inv_q;

  for (genvar t = 0; t < N_TERM; t++) begin : g_row
    logic row_hit;
    assign row_hit = wr_en_i && (wr_row_i == ROW_W'(t));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cube_q[t] <= '1;
        conn_q[t] <= '0;
      end else if (row_hit) begin
        if (wr_sel_i == SEL_CUBE) cube_q[t] <= wr_data_i[2*N_IN-1:0];
        if (wr_sel_i == SEL_CONN) conn_q[t] <= wr_data_i[N_OUT-1:0];
      end
    end

    assign cube_o[t] = cube_q[t];
    assign conn_o[t] = conn_q[t];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inv_q <= '0;
    else if (wr_en_i && wr_sel_i == SEL_INV) inv_q <= wr_data_i[N_OUT-1:0];
  end

  assign inv_o = inv_q;
endmodule

// File: rtl/pla_fault_overlay.sv
module pla_fault_overlay
  import pla_fault_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_TERM = 48,
  parameter int N_OUT  = 8,
  parameter int ROW_W  = 6,
  parameter int COL_W  = 4
) (
  input  logic [N_TERM-1:0][2*N_IN-1:0] cube_i,
  input  logic [N_TERM-1:0][N_OUT-1:0]  conn_i,
  input  logic                          flt_act_i,
  input  flt_kind_e                     flt_kind_i,
  input  logic [ROW_W-1:0]              flt_row_i,
  input  logic [COL_W-1:0]              flt_col_i,
  input  logic                          flt_val_i,
  output logic [N_TERM-1:0][2*N_IN-1:0] cube_o,
  output logic [N_TERM-1:0][N_OUT-1:0]  conn_o
);
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic row_sel;
    assign row_sel = flt_act_i && (flt_row_i == ROW_W'(t));

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      logic       hit;
      logic [1:0] code;
      logic       is_lit;
      assign hit    = row_sel && (flt_col_i == COL_W'(i));
      assign code   = cube_i[t][2*i +: 2];
      assign is_lit = (code == CODE_ONE) || (code == CODE_ZERO);
      // growth only on a literal, shrinkage only on an absent input
      assign cube_o[t][2*i +: 2] =
          (hit && flt_kind_i == FLT_GROW && is_lit)                 ? CODE_ABSENT :
          (hit && flt_kind_i == FLT_SHRINK && code == CODE_ABSENT)  ?
              (flt_val_i ? CODE_ONE : CODE_ZERO) : code;
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_con
      logic hit;
      assign hit = row_sel && (flt_col_i == COL_W'(o));
      assign conn_o[t][o] = (hit && flt_kind_i == FLT_DROP) ? 1'b0 :
                            (hit && flt_kind_i == FLT_ADD)  ? 1'b1 : conn_i[t][o];
    end
  end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_fault_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_TERM = 48
) (
  input  logic [N_TERM-1:0][2*N_IN-1:0] cube_i,
  input  logic [N_IN-1:0]               x_i,
  output logic [N_TERM-1:0]             term_o
);
  logic [N_TERM-1:0][N_IN-1:0] lit_ok;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      logic [1:0] code;
      assign code = cube_i[t][2*i +: 2];
      // code 00 matches nothing and kills the term
      assign lit_ok[t][i] = (code == CODE_ABSENT)
                          | ((code == CODE_ONE)  &  x_i[i])
                          | ((code == CODE_ZERO) & ~x_i[i]);
    end
    assign term_o[t] = &lit_ok[t];
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 48,
  parameter int N_OUT  = 8
) (
  input  logic [N_TERM-1:0]            term_i,
  input  logic [N_TERM-1:0][N_OUT-1:0] conn_i,
  input  logic [N_OUT-1:0]             inv_i,
  output logic [N_OUT-1:0]             z_o
);
  logic [N_OUT-1:0][N_TERM-1:0] feed;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
      assign feed[o][t] = term_i[t] & conn_i[t][o];
    end
    assign z_o[o] = (|feed[o]) ^ inv_i[o];
  end
endmodule

// File: rtl/pla_fault_array.sv
module pla_fault_array
  import pla_fault_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_TERM = 48,
  parameter int N_OUT  = 8,
  localparam int COL_N = (N_IN > N_OUT) ? N_IN : N_OUT,
  localparam int ROW_W = (N_TERM > 1) ? $clog2(N_TERM) : 1,
  localparam int COL_W = (COL_N > 1) ? $clog2(COL_N) : 1,
  localparam int WD_W  = (2*N_IN > N_OUT) ? 2*N_IN : N_OUT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [WD_W-1:0]  wr_data_i,
  input  logic             flt_set_i,
  input  logic             flt_clr_i,
  input  logic [1:0]       flt_type_i,
  input  logic [ROW_W-1:0] flt_row_i,
  input  logic [COL_W-1:0] flt_col_i,
  input  logic             flt_val_i,
  input  logic             in_valid_i,
  input  logic [N_IN-1:0]  in_vec_i,
  output logic             out_valid_o,
  output logic [N_OUT-1:0] z_o
);
  logic [N_TERM-1:0][2*N_IN-1:0] cube_raw, cube_eff;
  logic [N_TERM-1:0][N_OUT-1:0]  conn_raw, conn_eff;
  logic [N_OUT-1:0]              inv_q;
  logic [N_TERM-1:0]             term;
  logic [N_OUT-1:0]              z_comb;

  logic             flt_act_q;
  flt_kind_e        flt_kind_q;
  logic [ROW_W-1:0] flt_row_q;
  logic [COL_W-1:0] flt_col_q;
  logic             flt_val_q;

  logic             out_valid_q;
  logic [N_OUT-1:0] z_q;

  pla_prog_store #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .ROW_W(ROW_W), .WD_W(WD_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_row_i (wr_row_i),
    .wr_data_i(wr_data_i),
    .cube_o   (cube_raw),
    .conn_o   (conn_raw),
    .inv_o    (inv_q)
  );

  // single fault register; clear has priority
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_act_q  <= 1'b0;
      flt_kind_q <= FLT_GROW;
      flt_row_q  <= '0;
      flt_col_q  <= '0;
      flt_val_q  <= 1'b0;
    end else if (flt_clr_i) begin
      flt_act_q  <= 1'b0;
    end else if (flt_set_i) begin
      flt_act_q  <= 1'b1;
      flt_kind_q <= flt_kind_e'(flt_type_i);
      flt_row_q  <= flt_row_i;
      flt_col_q  <= flt_col_i;
      flt_val_q  <= flt_val_i;
    end
  end

  pla_fault_overlay #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_overlay (
    .cube_i    (cube_raw),
    .conn_i    (conn_raw),
    .flt_act_i (flt_act_q),
    .flt_kind_i(flt_kind_q),
    .flt_row_i (flt_row_q),
    .flt_col_i (flt_col_q),
    .flt_val_i (flt_val_q),
    .cube_o    (cube_eff),
    .conn_o    (conn_eff)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .cube_i(cube_eff),
    .x_i   (in_vec_i),
    .term_o(term)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term_i(term),
    .conn_i(conn_eff),
    .inv_i (inv_q),
    .z_o   (z_comb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      z_q         <= '0;
    end else begin
      out_valid_q <= in_valid_i;
      if (in_valid_i) z_q <= z_comb;
    end
  end

  assign out_valid_o = out_valid_q;
  assign z_o         = z_q;
endmodule

// File: rtl/pla_fault_chk.sv
module pla_fault_chk #(
  parameter int N_OUT = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             out_valid_o,
  input logic [N_OUT-1:0] z_o,
  input logic             flt_set_i,
  input logic             flt_clr_i,
  input logic             flt_act
);
  a_r4_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  a_r4_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  a_r4_result_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(z_o));

  a_r10_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_clr_i |=> !flt_act);

  a_r10_set_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_set_i && !flt_clr_i) |=> flt_act);

  a_r10_fault_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flt_set_i && !flt_clr_i) |=> $stable(flt_act));
endmodule

bind pla_fault_array pla_fault_chk #(.N_OUT(N_OUT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .out_valid_o(out_valid_o),
  .z_o        (z_o),
  .flt_set_i  (flt_set_i),
  .flt_clr_i  (flt_clr_i),
  .flt_act    (flt_act_q)
);

// File: tb/sim_pla_fault_array.sv
`timescale 1ns/1ps
module sim_pla_fault_array;
  localparam int NI = 4;
  localparam int NT = 6;
  localparam int NO = 3;
  localparam int RW = 3;
  localparam int CW = 2;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [RW-1:0] wr_row = '0;
  logic [DW-1:0] wr_data = '0;
  logic          flt_set = 1'b0, flt_clr = 1'b0;
  logic [1:0]    flt_type = '0;
  logic [RW-1:0] flt_row = '0;
  logic [CW-1:0] flt_col = '0;
  logic          flt_val = 1'b0;
  logic          in_valid = 1'b0;
  logic [NI-1:0] in_vec = '0;
  logic          out_valid;
  logic [NO-1:0] z;

  int total = 0;
  int bad = 0;

  logic [2*NI-1:0] m_cube [NT];
  logic [NO-1:0]   m_conn [NT];
  logic [NO-1:0]   m_inv;
  logic            f_act = 1'b0;
  int              f_kind = 0, f_row = 0, f_col = 0, f_val = 0;

  always #2 clk = ~clk;

  pla_fault_array #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_row_i(wr_row), .wr_data_i(wr_data),
    .flt_set_i(flt_set), .flt_clr_i(flt_clr), .flt_type_i(flt_type),
    .flt_row_i(flt_row), .flt_col_i(flt_col), .flt_val_i(flt_val),
    .in_valid_i(in_valid), .in_vec_i(in_vec),
    .out_valid_o(out_valid), .z_o(z)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NO-1:0] model(input logic [NI-1:0] x);
    logic [NO-1:0] r = '0;
    for (int t = 0; t < NT; t++) begin
      logic term = 1'b1;
      for (int i = 0; i < NI; i++) begin
        logic [1:0] c = m_cube[t][2*i +: 2];
        if (f_act && f_row == t && f_col == i) begin
          if (f_kind == 0 && (c == 2'b01 || c == 2'b10)) c = 2'b11;
          else if (f_kind == 1 && c == 2'b11) c = f_val ? 2'b01 : 2'b10;
        end
        if (c == 2'b00) term = 1'b0;
        if (c == 2'b01 && !x[i]) term = 1'b0;
        if (c == 2'b10 && x[i]) term = 1'b0;
      end
      for (int o = 0; o < NO; o++) begin
        logic cn = m_conn[t][o];
        if (f_act && f_row == t && f_col == o) begin
          if (f_kind == 2) cn = 1'b0;
          if (f_kind == 3) cn = 1'b1;
        end
        if (term && cn) r[o] = 1'b1;
      end
    end
    return r ^ m_inv;
  endfunction

  task automatic wr(input logic [1:0] sel, input int row, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_row = RW'(row); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel == 2'b00 && row < NT) m_cube[row] = d;
    if (sel == 2'b01 && row < NT) m_conn[row] = d[NO-1:0];
    if (sel == 2'b10) m_inv = d[NO-1:0];
  endtask

  task automatic sweep(input string tag);
    for (int x = 0; x < (1 << NI); x++) begin
      @(negedge clk);
      in_valid = 1'b1; in_vec = NI'(x);
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("%s x=%0h", tag, x), 32'(z), 32'(model(NI'(x))));
    end
  endtask

  task automatic arm(input int kind, input int row, input int col, input int val);
    @(negedge clk);
    flt_set = 1'b1; flt_type = 2'(kind); flt_row = RW'(row);
    flt_col = CW'(col); flt_val = val[0];
    @(negedge clk);
    flt_set = 1'b0;
    f_act = 1'b1; f_kind = kind; f_row = row; f_col = col; f_val = val;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) begin m_cube[t] = '1; m_conn[t] = '0; end
    m_inv = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 z_o after reset", 32'(z), 0);
    chk("R1 out_valid_o after reset", 32'(out_valid), 0);
    rst_ni = 1'b1;
    sweep("R1 cleared arrays");

    // R2 all codes incl. illegal 00 in row 4; R3 sums
    wr(2'b00, 0, 8'hF9); wr(2'b00, 1, 8'h67); wr(2'b00, 2, 8'hDA);
    wr(2'b00, 3, 8'hBF); wr(2'b00, 4, 8'hC7); wr(2'b00, 5, 8'h55);
    wr(2'b01, 0, 8'h01); wr(2'b01, 1, 8'h03); wr(2'b01, 2, 8'h04);
    wr(2'b01, 3, 8'h02); wr(2'b01, 4, 8'h07); wr(2'b01, 5, 8'h04);
    sweep("R2 R3 programmed");
    wr(2'b10, 0, 8'h05);
    sweep("R3 polarity");

    // R5 ignored writes
    wr(2'b11, 0, 8'h00);
    wr(2'b00, 6, 8'h00);
    wr(2'b01, 7, 8'h07);
    sweep("R5 ignored writes");

    // R4 latency and hold
    @(negedge clk); in_valid = 1'b1; in_vec = 4'h5;
    @(negedge clk); in_valid = 1'b0;
    chk("R4 valid after strobe", 32'(out_valid), 1);
    chk("R4 result", 32'(z), 32'(model(4'h5)));
    for (int k = 0; k < 4; k++) begin
      in_vec = NI'(k * 3 + 1);
      @(negedge clk);
      chk("R4 valid low without strobe", 32'(out_valid), 0);
      chk("R4 result held", 32'(z), 32'(model(4'h5)));
    end

    // R6 growth, R7 shrinkage at every coordinate
    for (int r = 0; r < NT; r++)
      for (int c = 0; c < NI; c++) begin
        arm(0, r, c, 0); sweep($sformatf("R6 row%0d col%0d", r, c));
        arm(1, r, c, 0); sweep($sformatf("R7 v0 row%0d col%0d", r, c));
        arm(1, r, c, 1); sweep($sformatf("R7 v1 row%0d col%0d", r, c));
      end
    // R8 disappearance, R9 appearance at every connection
    for (int r = 0; r < NT; r++)
      for (int o = 0; o < NO; o++) begin
        arm(2, r, o, 0); sweep($sformatf("R8 row%0d out%0d", r, o));
        arm(3, r, o, 0); sweep($sformatf("R9 row%0d out%0d", r, o));
      end

    // R10 replacement, then clear priority
    arm(0, 0, 0, 0);
    arm(3, 2, 0, 0);
    sweep("R10 replaced fault");
    @(negedge clk);
    flt_set = 1'b1; flt_clr = 1'b1; flt_type = 2'd2; flt_row = 3'd1; flt_col = 2'd1;
    @(negedge clk);
    flt_set = 1'b0; flt_clr = 1'b0; f_act = 1'b0;
    sweep("R10 clear wins");
    arm(2, 4, 2, 0);
    @(negedge clk); flt_clr = 1'b1;
    @(negedge clk); flt_clr = 1'b0; f_act = 1'b0;
    sweep("R11 restored without reload");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule